// File: doc/BRIEF.md
# Serial Debug Register Readout Port

This block is the target end of a two-wire in-circuit debug link. The host drives a slow serial clock and one shared data line. The bidirectional line is split into a data input, a data output and an output enable, which the pad ring joins. The host opens every command by shifting a 4-bit control code into the target while the line is an input. If the code is the readout command, the target waits through a fixed run of idle serial clocks. It then drives its 16-bit visibility word onto the line, one bit per serial clock. It keeps the line driven past the last bit until the host starts its next command. Every other code is treated as a no-op, and the target goes straight back to waiting for a code.

The serial clock and data pins are sampled into the system clock domain through a two-flop synchroniser. Serial edges are recognised from the synchronised clock, so the outputs respond a few system cycles after each serial edge. The serial clock must therefore run much slower than the system clock.

The visibility word is written through a valid/ready stream input. Ready is held high at all times, so there is no back-pressure, and a word is accepted on every system cycle in which valid is high. The last word accepted before the end of the idle run is the one sent. A word accepted while a readout is shifting takes effect from the next readout.

Top module: `dbg_readout_port`

## Requirements
- R1: While `rst` is high at a system clock edge, the block returns to code fetch with `sdat_oe` low and `sdat_o` low, and it clears the stored visibility word to zero.
- R2: Control-code bits are sampled on rising serial clock edges and assembled least significant bit first. The readout code is 4'b0001, which appears on the line as 1, 0, 0, 0.
- R3: After the readout code, the line stays an input (`sdat_oe` low) through the next 8 serial clock cycles.
- R4: The word sent is the stored visibility word at the 8th idle rising edge. A word accepted on `vis_valid`/`vis_ready` after that point does not change the transfer in progress. `vis_ready` is always high.
- R5: From the first falling edge after the idle run, `sdat_oe` is high. The 16 bits go out least significant bit first, each changing after a falling edge, so the host reads them on the next 16 rising edges.
- R6: After the 16th bit, `sdat_oe` and `sdat_o` hold until the next rising serial edge. That edge releases the line, and the data sampled on it is taken as bit 0 of the next control code.
- R7: Any other 4-bit code leaves `sdat_oe` low and returns the block to fetching a fresh control code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| sdat_i | input | 1 | Serial data from the line |
| sdat_o | output | 1 | Serial data driven onto the line |
| sdat_oe | output | 1 | High while the target drives the line |
| vis_valid | input | 1 | Visibility word offered |
| vis_ready | output | 1 | Visibility word accepted (always high) |
| vis_data | input | 16 | Visibility word value |

## Verification
A wrong internal state shows at the ports as one of three things: a readout word that is shifted or misordered, `sdat_oe` rising inside the idle gap or after a non-readout code, or the line released one edge too early or too late. A sequencer that is off by one edge corrupts the very next readout word, or moves the direction turn-around by one serial clock. Either fault appears within a single command of about 29 serial clocks. A wrong capture point for the visibility word appears in the one readout during which the word is rewritten.

// File: rtl/dbgro_pkg.sv
package dbgro_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } dbgro_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dbgro_sync.sv
module dbgro_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_pin,
  input  logic sdat_pin,
  output logic rise_o,
  output logic fall_o,
  output logic sdat_o
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          ck_q <= '0;
          dt_q <= '0;
        end else begin
          ck_q <= sclk_pin;
          dt_q <= sdat_pin;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          ck_q <= '0;
          dt_q <= '0;
        end else begin
          ck_q <= {ck_q[STAGES-2:0], sclk_pin};
          dt_q <= {dt_q[STAGES-2:0], sdat_pin};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ck_prev <= 1'b0;
    else     ck_prev <= ck_q[STAGES-1];
  end

  assign rise_o = ck_q[STAGES-1] & ~ck_prev;
  assign fall_o = ~ck_q[STAGES-1] & ck_prev;
  assign sdat_o = dt_q[STAGES-1];

  // R2: a rising edge is reported only once the synchronised clock was low a cycle earlier
  p_rise_from_low_r2: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> $past(ck_q[STAGES-1]) == 1'b0);
endmodule

// File: rtl/dbgro_visreg.sv
module dbgro_visreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o
);
  assign ready_o = 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          word_o <= '0;
    else if (valid_i) word_o <= data_i;
  end

  // R4: an accepted word is stored in the following cycle
  p_vis_load_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ready_o) |=> word_o == $past(data_i));
endmodule

// File: rtl/dbgro_fsm.sv
module dbgro_fsm
  import dbgro_pkg::*;
#(
  parameter int          CODE_W    = 4,
  parameter int          IDLE_CYC  = 8,
  parameter int          DATA_W    = 16,
  parameter logic [3:0]  READ_CODE = 4'b0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] vis_word_i,
  output logic              dout_o,
  output logic              oe_o
);
  localparam int MAXC  = max3(CODE_W, IDLE_CYC, DATA_W);
  localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_W - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CODE_W-1:0] RD_CODE  = CODE_W'(READ_CODE);

  dbgro_state_e      state;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  logic [DATA_W-1:0] shreg;
  logic              dout_q;
  logic              oe_q;

  // LSB first: the newest bit enters at the top and moves down
  assign code_nxt = {din_i, code_q[CODE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      cnt    <= '0;
      code_q <= '0;
      shreg  <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          if (rise_i) begin
            code_q <= code_nxt;
            if (cnt == CODE_LAST) begin
              cnt <= '0;
              if (code_nxt == RD_CODE) state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_IDLE: begin
          if (rise_i) begin
            if (cnt == IDLE_LAST) begin
              cnt   <= '0;
              shreg <= vis_word_i;
              state <= ST_SHIFT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (fall_i) begin
            dout_q <= shreg[0];
            shreg  <= shreg >> 1;
            oe_q   <= 1'b1;
          end
          if (rise_i) begin
            if (cnt == DATA_LAST) begin
              cnt   <= '0;
              state <= ST_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (rise_i) begin
            oe_q   <= 1'b0;
            code_q <= code_nxt;
            cnt    <= CNT_W'(1);
            state  <= ST_FETCH;
          end
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;

  // R3: the line is never driven during the idle gap
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !oe_q);

  // R7: the line is an input whenever a control code is being fetched
  p_fetch_input_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> !oe_q);

  // R4: shifting is only ever entered from the idle gap
  p_shift_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && $past(state) != ST_SHIFT) |-> $past(state) == ST_IDLE);

  // R6: while holding and no rising edge arrives, the driven bit stays put
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !rise_i) |=> ($stable(dout_q) && oe_q));

  // R6: the rising edge that ends the hold releases the line
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && rise_i) |=> (!oe_q && state == ST_FETCH));

  // R7: a finished non-readout code keeps the block in fetch
  p_other_code_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && rise_i && cnt == CODE_LAST && code_nxt != RD_CODE)
      |=> (state == ST_FETCH && !oe_q));
endmodule

// File: rtl/dbg_readout_port.sv
module dbg_readout_port #(
  parameter int         DATA_W      = 16,
  parameter int         CODE_W      = 4,
  parameter int         IDLE_CYC    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] READ_CODE   = 4'b0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic              sdat_oe,
  input  logic              vis_valid,
  output logic              vis_ready,
  input  logic [DATA_W-1:0] vis_data
);
  logic              rise_s;
  logic              fall_s;
  logic              din_s;
  logic [DATA_W-1:0] vis_word;

  dbgro_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sclk_pin (sclk_i),
    .sdat_pin (sdat_i),
    .rise_o   (rise_s),
    .fall_o   (fall_s),
    .sdat_o   (din_s)
  );

  dbgro_visreg #(.DATA_W(DATA_W)) u_vis (
    .clk     (clk),
    .rst     (rst),
    .valid_i (vis_valid),
    .ready_o (vis_ready),
    .data_i  (vis_data),
    .word_o  (vis_word)
  );

  dbgro_fsm #(
    .CODE_W    (CODE_W),
    .IDLE_CYC  (IDLE_CYC),
    .DATA_W    (DATA_W),
    .READ_CODE (READ_CODE)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise_s),
    .fall_i     (fall_s),
    .din_i      (din_s),
    .vis_word_i (vis_word),
    .dout_o     (sdat_o),
    .oe_o       (sdat_oe)
  );

  // R1: one cycle after reset the line is released and low
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sdat_oe && !sdat_o));
endmodule

// File: tb/tb_dbg_readout_port.sv
module tb_dbg_readout_port;
  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_i = 1'b0;
  logic        sdat_i = 1'b0;
  logic        vis_valid = 1'b0;
  logic [15:0] vis_data = '0;
  logic        sdat_o;
  logic        sdat_oe;
  logic        vis_ready;

  int          n_run = 0;
  int          n_fail = 0;
  logic [15:0] exp_q[$];
  logic        oe_hi = 1'b0;
  bit          finished = 0;

  always #4 clk = ~clk;

  dbg_readout_port dut (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (sclk_i),
    .sdat_i    (sdat_i),
    .sdat_o    (sdat_o),
    .sdat_oe   (sdat_oe),
    .vis_valid (vis_valid),
    .vis_ready (vis_ready),
    .vis_data  (vis_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ser_cycle(input logic d);
    sdat_i = d;
    repeat (HP) @(negedge clk);
    sclk_i = 1'b1;
    repeat (HP) @(negedge clk);
    oe_hi  = sdat_oe;
    sclk_i = 1'b0;
  endtask

  task automatic load_vis(input logic [15:0] v);
    vis_valid = 1'b1;
    vis_data  = v;
    @(negedge clk);
    chk(vis_ready == 1'b1, "R4 vis_ready high", 32'(vis_ready), 1);
    vis_valid = 1'b0;
  endtask

  // readout: code 4'b0001 sent LSB first (1,0,0,0), 8 idle, 16 data clocks
  task automatic do_read(input logic [15:0] exp, input bit upd, input logic [15:0] nv);
    bit quiet = 1;
    exp_q.push_back(exp);
    ser_cycle(1'b1);
    chk(oe_hi == 1'b0, "R6 line released on first code edge", 32'(oe_hi), 0);
    ser_cycle(1'b0); ser_cycle(1'b0); ser_cycle(1'b0);
    for (int i = 0; i < 8; i++) begin
      ser_cycle(1'b0);
      if (oe_hi) quiet = 0;
    end
    chk(quiet, "R3 no drive in idle gap", 32'(!quiet), 0);
    for (int i = 0; i < 16; i++) begin
      ser_cycle(1'b0);
      if (upd && i == 5) load_vis(nv);
    end
    repeat (HP/2) @(negedge clk);
    chk(sdat_oe && sdat_o == exp[15], "R6 hold after last bit",
        {30'd0, sdat_oe, sdat_o}, {30'd0, 1'b1, exp[15]});
  endtask

  task automatic other_code(input logic [3:0] c, input string tag);
    bit quiet = 1;
    for (int i = 0; i < 4; i++) begin
      ser_cycle(c[i]);
      if (oe_hi && i > 0) quiet = 0;
    end
    for (int i = 0; i < 28; i++) begin
      ser_cycle(1'b0);
      if (oe_hi) quiet = 0;
    end
    chk(quiet, tag, 32'(!quiet), 0);
  endtask

  // scoreboard monitor: gathers driven bits at rising serial edges
  initial begin
    int          n = 0;
    bit          skip = 0;
    logic [15:0] w = '0;
    logic [15:0] e;
    forever begin
      @(posedge sclk_i or posedge rst);
      if (rst) begin
        n = 0;
        skip = 0;
      end else if (skip) begin
        skip = 0;
      end else if (sdat_oe) begin
        w[n] = sdat_o;
        n++;
        if (n == 16) begin
          if (exp_q.size() == 0) begin
            chk(0, "R5 unexpected readout word", 32'(w), 0);
          end else begin
            e = exp_q.pop_front();
            chk(w == e, "R5 readout word LSB first", 32'(w), 32'(e));
          end
          n = 0;
          skip = 1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sdat_oe == 1'b0, "R1 reset oe low", 32'(sdat_oe), 0);
    chk(sdat_o == 1'b0, "R1 reset data low", 32'(sdat_o), 0);

    // R2/R5: several patterns, back-to-back commands exercise R6 release
    load_vis(16'hA5C3);
    do_read(16'hA5C3, 0, 16'h0);
    load_vis(16'h8000);
    do_read(16'h8000, 0, 16'h0);
    load_vis(16'hFFFF);
    do_read(16'hFFFF, 0, 16'h0);
    load_vis(16'h0001);
    do_read(16'h0001, 0, 16'h0);

    // R7: other codes, including 4'b1000 (line order 0,0,0,1) for R2 ordering
    other_code(4'b0101, "R7 code 0101 leaves line input");
    other_code(4'b1000, "R2 code 1000 is not readout");
    load_vis(16'h3C96);
    do_read(16'h3C96, 0, 16'h0);

    // R4: rewrite during shifting, then the new word on the next readout
    load_vis(16'h1234);
    do_read(16'h1234, 1, 16'hABCD);
    do_read(16'hABCD, 0, 16'h0);

    // R1: reset in the middle of a readout
    load_vis(16'h5555);
    for (int i = 0; i < 4; i++) ser_cycle(i == 0);
    for (int i = 0; i < 8; i++) ser_cycle(1'b0);
    for (int i = 0; i < 5; i++) ser_cycle(1'b0);
    chk(sdat_oe == 1'b1, "R5 driving during shift", 32'(sdat_oe), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdat_oe == 1'b0 && sdat_o == 1'b0, "R1 reset mid readout",
        {30'd0, sdat_oe, sdat_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    do_read(16'h0000, 0, 16'h0);

    ser_cycle(1'b0);
    repeat (4 * HP) @(negedge clk);
    chk(exp_q.size() == 0, "R5 every readout word produced", 32'(exp_q.size()), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule